// File: doc/BRIEF.md
# Threshold-Flagged Byte FIFO Pair with Self-Clearing Flush

This block sits between a register interface and a serial bus sequencer and holds two byte queues. The transmit queue is filled from the register side and drained by the sequencer. The receive queue is filled by the sequencer and drained from the register side. Each queue has 16 entries of 8 bits. Both queues present their head byte on the read-data output before the pop (show-ahead). Each queue also reports its fill level and a set of level flags that an interrupt unit can mask and latch.

Each queue has a 4-bit threshold input. The transmit side reports "nearly empty" when its level is at or below its threshold. The receive side reports "nearly full" when its level is at or above its threshold. A push into a full transmit queue drops the byte and sets an overrun flag, which stays set until a clear pulse arrives. Each queue has its own flush command. A flush empties that queue at once and then holds a busy bit high for a fixed number of cycles. During those cycles the queue ignores pushes and pops. The busy bit then clears itself.

Top module: `fifo_pair`

## Requirements
- R1: After reset both levels are 0, both empty flags are 1, both full flags are 0, both flush-busy outputs are 0 and the overrun flag is 0.
- R2: Each queue returns bytes in the order they were accepted. The read-data output shows the head byte before the pop that removes it.
- R3: A queue's level never exceeds 16. The full flag is 1 exactly at level 16 and the empty flag is 1 exactly at level 0.
- R4: The transmit nearly-empty flag is 1 exactly when the transmit level is less than or equal to the transmit threshold (0 to 15).
- R5: The receive nearly-full flag is 1 exactly when the receive level is greater than or equal to the receive threshold (0 to 15), so a threshold of 0 keeps it at 1.
- R6: A push into the full transmit queue is not stored. It sets the overrun flag, which stays 1 with no clear pulse.
- R7: A clear pulse on the overrun-clear input resets the overrun flag on the next edge. A new overrun in the same cycle takes priority over the clear.
- R8: A flush request on an idle queue empties it on that edge. The queue's busy output is then 1 for exactly 4 cycles and returns to 0 by itself. A request made while busy is ignored.
- R9: While a queue's flush is busy, pushes and pops to that queue have no effect and do not set the overrun flag.
- R10: A pop from an empty queue leaves the level at 0, and the read-data output is 0 while the queue is empty.
- R11: A push into the full receive queue is dropped and does not set the overrun flag.
- R12: Flushing one queue leaves the other queue's contents and level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_thr_i | input | 4 | Transmit nearly-empty threshold |
| rx_thr_i | input | 4 | Receive nearly-full threshold |
| tx_flush_i | input | 1 | Transmit flush request |
| rx_flush_i | input | 1 | Receive flush request |
| tx_flush_busy_o | output | 1 | Transmit flush in progress |
| rx_flush_busy_o | output | 1 | Receive flush in progress |
| tx_wr_i | input | 1 | Push into transmit queue (register side) |
| tx_wdata_i | input | 8 | Transmit push data |
| tx_rd_i | input | 1 | Pop from transmit queue (sequencer side) |
| tx_rdata_o | output | 8 | Transmit head byte, 0 when empty |
| rx_wr_i | input | 1 | Push into receive queue (sequencer side) |
| rx_wdata_i | input | 8 | Receive push data |
| rx_rd_i | input | 1 | Pop from receive queue (register side) |
| rx_rdata_o | output | 8 | Receive head byte, 0 when empty |
| tx_level_o | output | 5 | Transmit fill level |
| rx_level_o | output | 5 | Receive fill level |
| tx_empty_o | output | 1 | Transmit level is 0 |
| tx_near_empty_o | output | 1 | Transmit level at or below threshold |
| tx_full_o | output | 1 | Transmit level is 16 |
| rx_empty_o | output | 1 | Receive level is 0 |
| rx_near_full_o | output | 1 | Receive level at or above threshold |
| rx_full_o | output | 1 | Receive level is 16 |
| tx_ovr_o | output | 1 | Sticky transmit overrun flag |
| tx_ovr_clr_i | input | 1 | Overrun clear pulse |

## Verification
The assertions check several properties on every cycle: the level stays bounded, the empty and full flags never conflict, a queue stays empty throughout its flush window, a pop on an empty queue leaves it empty, the overrun flag stays set without a clear, and the busy bit does not drop out early. Other behaviour shows up only in the bench's scenarios: byte ordering through the queues, proof that a dropped byte never appears, the threshold comparisons across several thresholds, the exact four-cycle busy length, and the independence of the two flushes.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  localparam int unsigned DEPTH_DEF    = 16;
  localparam int unsigned DATA_W_DEF   = 8;
  localparam int unsigned THR_W_DEF    = 4;
  localparam int unsigned FLUSH_CYC_DEF = 4;

  typedef struct packed {
    logic empty;
    logic near;
    logic full;
  } lvl_flags_t;
endpackage

// File: rtl/fifo_flush_seq.sv
module fifo_flush_seq #(
  parameter int unsigned FLUSH_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic start_o,
  output logic busy_o
);
  localparam int unsigned CNT_W = $clog2(FLUSH_CYC + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  assign start_o = req_i & ~busy_q;
  assign busy_o  = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_o) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(FLUSH_CYC - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  // R8: the busy window never collapses to a single cycle
  a_r8_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |=> busy_q);
  // R8: a request while busy does not restart the sequence
  a_r8_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !start_o);
endmodule

// File: rtl/fifo_core.sv
module fifo_core #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = PTR_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              hold_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              drop_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wptr_q, rptr_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              full, empty, frozen, push_ok, pop_ok;

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign frozen  = hold_i | clear_i;
  assign push_ok = wr_i & ~full & ~frozen;
  assign pop_ok  = rd_i & ~empty & ~frozen;
  assign drop_o  = wr_i & full & ~frozen;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else if (clear_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= rptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign rdata_o = empty ? '0 : mem_q[rptr_q];
  assign level_o = lvl_q;

  // R3: level bounded by depth
  a_r3_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvl_q <= LVL_W'(DEPTH));
  // R9: queue stays empty through the flush window
  a_r9_frozen_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> lvl_q == '0);
  // R10: pop from empty leaves it empty
  a_r10_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !wr_i && lvl_q == '0) |=> lvl_q == '0);
endmodule

// File: rtl/fifo_level_flags.sv
module fifo_level_flags
  import fifo_pair_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned THR_W     = 4,
  parameter bit          NEAR_FULL = 1'b0,
  localparam int unsigned LVL_W    = $clog2(DEPTH) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LVL_W-1:0] level_i,
  input  logic [THR_W-1:0] thr_i,
  output lvl_flags_t       flags_o
);
  logic [LVL_W-1:0] thr_ext;
  assign thr_ext = LVL_W'(thr_i);

  assign flags_o.empty = (level_i == '0);
  assign flags_o.full  = (level_i == LVL_W'(DEPTH));

  generate
    if (NEAR_FULL) begin : g_near_full
      assign flags_o.near = (level_i >= thr_ext);
    end else begin : g_near_empty
      assign flags_o.near = (level_i <= thr_ext);
    end
  endgenerate

  // R3: empty and full are exclusive
  a_r3_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flags_o.empty, flags_o.full}));
endmodule

// File: rtl/fifo_ovr_flag.sv
module fifo_ovr_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  // R6: sticky without a clear
  a_r6_ovr_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  // R7: set wins over clear
  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
endmodule

// File: rtl/fifo_pair.sv
module fifo_pair
  import fifo_pair_pkg::*;
#(
  parameter int unsigned DEPTH     = DEPTH_DEF,
  parameter int unsigned DATA_W    = DATA_W_DEF,
  parameter int unsigned THR_W     = THR_W_DEF,
  parameter int unsigned FLUSH_CYC = FLUSH_CYC_DEF,
  localparam int unsigned LVL_W    = $clog2(DEPTH) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [THR_W-1:0]  tx_thr_i,
  input  logic [THR_W-1:0]  rx_thr_i,
  input  logic              tx_flush_i,
  input  logic              rx_flush_i,
  output logic              tx_flush_busy_o,
  output logic              rx_flush_busy_o,
  input  logic              tx_wr_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              tx_rd_i,
  output logic [DATA_W-1:0] tx_rdata_o,
  input  logic              rx_wr_i,
  input  logic [DATA_W-1:0] rx_wdata_i,
  input  logic              rx_rd_i,
  output logic [DATA_W-1:0] rx_rdata_o,
  output logic [LVL_W-1:0]  tx_level_o,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic              tx_empty_o,
  output logic              tx_near_empty_o,
  output logic              tx_full_o,
  output logic              rx_empty_o,
  output logic              rx_near_full_o,
  output logic              rx_full_o,
  output logic              tx_ovr_o,
  input  logic              tx_ovr_clr_i
);
  logic       tx_start, rx_start, tx_drop, rx_drop_unused;
  lvl_flags_t tx_flags, rx_flags;

  // Per-direction flush sequencer and storage
  fifo_flush_seq #(.FLUSH_CYC(FLUSH_CYC)) u_tx_flush (
    .clk_i, .rst_ni, .req_i(tx_flush_i), .start_o(tx_start), .busy_o(tx_flush_busy_o));
  fifo_flush_seq #(.FLUSH_CYC(FLUSH_CYC)) u_rx_flush (
    .clk_i, .rst_ni, .req_i(rx_flush_i), .start_o(rx_start), .busy_o(rx_flush_busy_o));

  fifo_core #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_core (
    .clk_i, .rst_ni, .clear_i(tx_start), .hold_i(tx_flush_busy_o),
    .wr_i(tx_wr_i), .wdata_i(tx_wdata_i), .rd_i(tx_rd_i), .rdata_o(tx_rdata_o),
    .level_o(tx_level_o), .drop_o(tx_drop));
  fifo_core #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_core (
    .clk_i, .rst_ni, .clear_i(rx_start), .hold_i(rx_flush_busy_o),
    .wr_i(rx_wr_i), .wdata_i(rx_wdata_i), .rd_i(rx_rd_i), .rdata_o(rx_rdata_o),
    .level_o(rx_level_o), .drop_o(rx_drop_unused));

  fifo_level_flags #(.DEPTH(DEPTH), .THR_W(THR_W), .NEAR_FULL(1'b0)) u_tx_flags (
    .clk_i, .rst_ni, .level_i(tx_level_o), .thr_i(tx_thr_i), .flags_o(tx_flags));
  fifo_level_flags #(.DEPTH(DEPTH), .THR_W(THR_W), .NEAR_FULL(1'b1)) u_rx_flags (
    .clk_i, .rst_ni, .level_i(rx_level_o), .thr_i(rx_thr_i), .flags_o(rx_flags));

  fifo_ovr_flag u_tx_ovr (
    .clk_i, .rst_ni, .set_i(tx_drop), .clr_i(tx_ovr_clr_i), .flag_o(tx_ovr_o));

  assign tx_empty_o      = tx_flags.empty;
  assign tx_near_empty_o = tx_flags.near;
  assign tx_full_o       = tx_flags.full;
  assign rx_empty_o      = rx_flags.empty;
  assign rx_near_full_o  = rx_flags.near;
  assign rx_full_o       = rx_flags.full;

  // R11: the receive queue has no overrun path; a drop there is observable only as a held level
  a_r11_rx_drop_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_drop_unused && !rx_rd_i) |=> rx_level_o == LVL_W'(DEPTH));
  // R12: a transmit flush does not disturb the receive level
  a_r12_tx_flush_isolated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_start && !rx_start && !rx_flush_busy_o && !rx_wr_i && !rx_rd_i) |=> $stable(rx_level_o));
endmodule

// File: tb/tb_fifo_pair.sv
module tb_fifo_pair;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] tx_thr = '0, rx_thr = '0;
  logic       tx_flush = 0, rx_flush = 0, tx_wr = 0, tx_rd = 0, rx_wr = 0, rx_rd = 0, ovr_clr = 0;
  logic [7:0] tx_wdata = '0, rx_wdata = '0;
  logic       tx_busy, rx_busy, tx_empty, tx_ne, tx_full, rx_empty, rx_nf, rx_full, tx_ovr;
  logic [7:0] tx_rdata, rx_rdata;
  logic [4:0] tx_level, rx_level;

  int checks = 0, errors = 0;
  logic [7:0] txq[$], rxq[$];

  always #2 clk = ~clk;

  fifo_pair dut (
    .clk_i(clk), .rst_ni(rst_n), .tx_thr_i(tx_thr), .rx_thr_i(rx_thr),
    .tx_flush_i(tx_flush), .rx_flush_i(rx_flush),
    .tx_flush_busy_o(tx_busy), .rx_flush_busy_o(rx_busy),
    .tx_wr_i(tx_wr), .tx_wdata_i(tx_wdata), .tx_rd_i(tx_rd), .tx_rdata_o(tx_rdata),
    .rx_wr_i(rx_wr), .rx_wdata_i(rx_wdata), .rx_rd_i(rx_rd), .rx_rdata_o(rx_rdata),
    .tx_level_o(tx_level), .rx_level_o(rx_level),
    .tx_empty_o(tx_empty), .tx_near_empty_o(tx_ne), .tx_full_o(tx_full),
    .rx_empty_o(rx_empty), .rx_near_full_o(rx_nf), .rx_full_o(rx_full),
    .tx_ovr_o(tx_ovr), .tx_ovr_clr_i(ovr_clr));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: 1 ns after the falling edge the inputs are settled and outputs hold pre-edge values
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_rd && !tx_busy && !tx_flush) begin
      if (txq.size() > 0) begin
        logic [7:0] e;
        e = txq.pop_front();
        chk(tx_rdata == e, "R2 tx order", tx_rdata, e);
      end else chk(tx_rdata == 8'h00, "R10 tx empty data", tx_rdata, 0);
    end
    if (rst_n && rx_rd && !rx_busy && !rx_flush) begin
      if (rxq.size() > 0) begin
        logic [7:0] e;
        e = rxq.pop_front();
        chk(rx_rdata == e, "R2 rx order", rx_rdata, e);
      end else chk(rx_rdata == 8'h00, "R10 rx empty data", rx_rdata, 0);
    end
  end

  // Driver tasks: one operation per cycle, expected items queued only when the rules accept them
  task automatic tx_push(input logic [7:0] d);
    @(negedge clk);
    tx_wr = 1; tx_wdata = d;
    if (!tx_busy && txq.size() < 16) txq.push_back(d);
    @(negedge clk);
    tx_wr = 0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk);
    rx_wr = 1; rx_wdata = d;
    if (!rx_busy && rxq.size() < 16) rxq.push_back(d);
    @(negedge clk);
    rx_wr = 0;
  endtask

  task automatic tx_pop();
    @(negedge clk); tx_rd = 1;
    @(negedge clk); tx_rd = 0;
  endtask

  task automatic rx_pop();
    @(negedge clk); rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(tx_level == 0 && rx_level == 0, "R1 levels", tx_level + rx_level, 0);
    chk(tx_empty && rx_empty && !tx_full && !rx_full, "R1 flags",
        {tx_empty, rx_empty, tx_full, rx_full}, 4'b1100);
    chk(!tx_busy && !rx_busy && !tx_ovr, "R1 busy/ovr", {tx_busy, rx_busy, tx_ovr}, 0);

    // R2/R3 fill transmit, R4 nearly-empty tracking with threshold 5
    tx_thr = 4'd5;
    for (int i = 0; i < 16; i++) begin
      tx_push(8'(i * 7 + 3));
      chk(tx_level == 5'(i + 1), "R3 tx level", tx_level, i + 1);
      chk(tx_ne == (i + 1 <= 5), "R4 tx near empty", tx_ne, (i + 1 <= 5));
    end
    chk(tx_full && !tx_empty, "R3 tx full", tx_full, 1);
    tx_thr = 4'd15;
    #1 chk(tx_ne == 1'b0, "R4 thr15 at 16", tx_ne, 0);

    // R6 overrun: byte dropped, flag sticky
    tx_push(8'hEE);
    chk(tx_ovr == 1'b1, "R6 ovr set", tx_ovr, 1);
    chk(tx_level == 5'd16, "R6 level held", tx_level, 16);
    repeat (3) @(negedge clk);
    chk(tx_ovr == 1'b1, "R6 ovr sticky", tx_ovr, 1);

    tx_thr = 4'd0;
    for (int i = 0; i < 16; i++) tx_pop();
    chk(tx_empty && tx_level == 0, "R3 tx drained", tx_level, 0);
    chk(tx_ne == 1'b1, "R4 thr0 at 0", tx_ne, 1);

    // R10 pop from empty
    tx_pop();
    chk(tx_level == 0 && tx_rdata == 0, "R10 tx pop empty", tx_level, 0);

    // R7 clear
    @(negedge clk); ovr_clr = 1;
    @(negedge clk); ovr_clr = 0;
    chk(tx_ovr == 1'b0, "R7 ovr cleared", tx_ovr, 0);

    // R5 receive nearly-full, threshold 4, then threshold 0
    rx_thr = 4'd0;
    #1 chk(rx_nf == 1'b1, "R5 thr0 empty", rx_nf, 1);
    rx_thr = 4'd4;
    #1 chk(rx_nf == 1'b0, "R5 thr4 empty", rx_nf, 0);
    for (int i = 0; i < 16; i++) begin
      rx_push(8'(8'hA0 ^ i * 5));
      chk(rx_nf == (i + 1 >= 4), "R5 rx near full", rx_nf, (i + 1 >= 4));
    end
    chk(rx_full && rx_level == 16, "R3 rx full", rx_level, 16);
    // R11 drop on full receive
    rx_push(8'h55);
    chk(rx_level == 16 && !tx_ovr, "R11 rx drop no ovr", {rx_level, tx_ovr}, 32);
    for (int i = 0; i < 16; i++) rx_pop();
    rx_pop();
    chk(rx_level == 0 && rx_rdata == 0, "R10 rx pop empty", rx_level, 0);

    // Interleaved traffic in both directions
    for (int i = 0; i < 6; i++) begin
      tx_push(8'(8'h30 + i));
      rx_push(8'(8'h60 + i));
      if (i % 2 == 1) begin tx_pop(); rx_pop(); end
    end
    chk(tx_level == 3 && rx_level == 3, "R2 mixed levels", tx_level, 3);

    // R8/R9/R12 transmit flush
    @(negedge clk); tx_flush = 1;
    @(negedge clk); tx_flush = 0;
    txq.delete();
    for (int c = 0; c < 4; c++) begin
      chk(tx_busy == 1'b1, "R8 tx busy window", tx_busy, 1);
      if (c == 1) begin tx_wr = 1; tx_wdata = 8'h99; tx_flush = 1; end
      if (c == 2) begin tx_wr = 0; tx_flush = 0; tx_rd = 1; end
      if (c == 3) tx_rd = 0;
      @(negedge clk);
    end
    chk(tx_busy == 1'b0, "R8 tx busy self-clears", tx_busy, 0);
    chk(tx_level == 0 && tx_rdata == 0, "R9 tx ops ignored", tx_level, 0);
    chk(!tx_ovr, "R9 no ovr in flush", tx_ovr, 0);
    chk(rx_level == 3 && !rx_busy, "R12 rx untouched", rx_level, 3);

    // R8/R12 receive flush, transmit side survives
    tx_push(8'h11);
    @(negedge clk); rx_flush = 1;
    @(negedge clk); rx_flush = 0;
    rxq.delete();
    for (int c = 0; c < 4; c++) begin
      chk(rx_busy == 1'b1, "R8 rx busy window", rx_busy, 1);
      @(negedge clk);
    end
    chk(rx_busy == 1'b0 && rx_level == 0, "R8 rx flushed", rx_level, 0);
    chk(tx_level == 1, "R12 tx untouched", tx_level, 1);
    tx_pop();
    chk(tx_level == 0, "R2 tx after flush", tx_level, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule